// File: doc/BRIEF.md
# Hashed Empty/Full Inter-Stage Buffer

This block sits between two pipelined loop stages that touch the same logical array in different orders. The producer stage hands over an element as an (index, data) pair. The consumer stage asks for an index and is told in the same cycle whether the element is there. Storage is a small dual-ported data memory with a matching table of per-slot validity fields. Both are addressed by the logical index modulo the buffer depth. The depth is a power of two, so the slot address is just the low index bits.

Each write also says how many times the element will be consumed. The validity field of that slot is loaded with that many ones, and every successful read shifts it right by one place. The slot frees itself after the last permitted read. A consumer that misses simply repeats the same request on later cycles. A producer that targets a slot still holding unconsumed data is stalled and its write is dropped, so it must retry. Occupancy, its peak value, and store, hit and miss counts are brought out so the smallest safe depth can be measured.

Top module: `hash_ebuf`

## Requirements
- R1: After reset every slot is empty: all reads miss, and occupancy, peak occupancy and the store, hit and miss counts are zero.
- R2: The slot of an index is its low log2(DEPTH) bits. Indices that differ only above those bits share one slot.
- R3: An accepted write stores the data and marks the slot full at the clock edge. From the next cycle on, a read of any index mapping to that slot returns the data with rd_hit high, combinationally in the cycle of the request.
- R4: A read of an empty slot gives rd_hit low and changes no slot. The same read repeated after the slot is written hits.
- R5: A write carrying a use count L with 1 <= L <= MAX_READS allows exactly L hits, after which reads miss. L = 0 acts as 1, and L above MAX_READS acts as MAX_READS.
- R6: A write to a slot whose validity field is non-zero raises wr_stall in the same cycle and is discarded. The old data and the remaining uses are kept.
- R7: When a write and the final permitted read of one slot fall in the same cycle, the read returns the old data with a hit, wr_stall stays low, and the new data is stored with its own use count.
- R8: A write and a read to different slots in the same cycle do not affect each other.
- R9: Occupancy rises by one per accepted write and falls by one per final read. peak_occ holds the largest occupancy seen since reset.
- R10: store_cnt counts accepted writes, hit_cnt counts read hits, and miss_cnt counts read requests that miss.
- R11: Occupancy never exceeds DEPTH. With every slot full, any write without a same-slot final read stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Producer write request |
| wr_idx | input | IDX_W | Logical array index of the write |
| wr_data | input | DATA_W | Data to store |
| wr_uses | input | USE_W | Number of reads the element allows |
| wr_stall | output | 1 | Write rejected because the slot still holds data |
| rd_en | input | 1 | Consumer read request |
| rd_idx | input | IDX_W | Logical array index of the read |
| rd_data | output | DATA_W | Data held in the addressed slot |
| rd_hit | output | 1 | Slot held valid data; the read consumed one use |
| occupancy | output | OCC_W | Slots currently holding data |
| peak_occ | output | OCC_W | Highest occupancy since reset |
| store_cnt | output | CNT_W | Accepted writes |
| hit_cnt | output | CNT_W | Read hits |
| miss_cnt | output | CNT_W | Read misses |

## Verification
The read port and the write port can meet on one slot in the same cycle. The outcome then depends on whether that read takes the last use. The bench provokes this in two ways: a write aimed at a slot being read for its last use, and one aimed at a slot being read with uses still left. It also mixes both ports at random over a small buffer and judges each cycle against a use-count model kept in the bench. The model decides stall or refill, and which data the reader sees, by ordering the read before the write.

// File: rtl/hebuf_pkg.sv
package hebuf_pkg;

  // Slot address: low bits of the logical index (depth is a power of two)
  function automatic int unsigned slot_of(int unsigned idx, int unsigned depth);
    return idx & (depth - 1);
  endfunction

  // Validity pattern for a use count: n ones, with n clamped to 1..max_reads
  function automatic int unsigned fill_mask(int unsigned uses, int unsigned max_reads);
    int unsigned n;
    n = (uses == 0) ? 1 : ((uses > max_reads) ? max_reads : uses);
    return (1 << n) - 1;
  endfunction

  // A field with only its lowest bit set has exactly one use left
  function automatic logic last_use(int unsigned field);
    return field == 1;
  endfunction

endpackage

// File: rtl/hebuf_store.sv
module hebuf_store #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 16,
  localparam int SLOT_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [SLOT_W-1:0] wslot,
  input  logic [DATA_W-1:0] wdata,
  input  logic [SLOT_W-1:0] rslot,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wslot] <= wdata;
  end

  assign rdata = mem[rslot];
endmodule

// File: rtl/hebuf_flags.sv
module hebuf_flags #(
  parameter int DEPTH = 8,
  parameter int FLD_W = 4,
  localparam int SLOT_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SLOT_W-1:0] rd_slot,
  input  logic [SLOT_W-1:0] wr_slot,
  output logic [FLD_W-1:0]  rd_field,
  output logic [FLD_W-1:0]  wr_field,
  input  logic              pop_en,
  input  logic              set_en,
  input  logic [FLD_W-1:0]  set_val
);
  logic [FLD_W-1:0] fld [DEPTH];

  assign rd_field = fld[rd_slot];
  assign wr_field = fld[wr_slot];

  // Read update first, write second: a refill of a freed slot wins
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) fld[i] <= '0;
    end else begin
      if (pop_en) fld[rd_slot] <= rd_field >> 1;
      if (set_en) fld[wr_slot] <= set_val;
    end
  end
endmodule

// File: rtl/hebuf_stats.sv
module hebuf_stats #(
  parameter int OCC_W = 4,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             hit,
  input  logic             miss,
  input  logic             free,
  output logic [OCC_W-1:0] occ,
  output logic [OCC_W-1:0] peak,
  output logic [CNT_W-1:0] st_cnt,
  output logic [CNT_W-1:0] h_cnt,
  output logic [CNT_W-1:0] m_cnt
);
  logic [OCC_W-1:0] occ_nxt;
  assign occ_nxt = occ + OCC_W'(accept) - OCC_W'(free);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ    <= '0;
      peak   <= '0;
      st_cnt <= '0;
      h_cnt  <= '0;
      m_cnt  <= '0;
    end else begin
      occ <= occ_nxt;
      if (occ_nxt > peak) peak <= occ_nxt;
      if (accept) st_cnt <= st_cnt + 1'b1;
      if (hit)    h_cnt  <= h_cnt + 1'b1;
      if (miss)   m_cnt  <= m_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/hash_ebuf.sv
module hash_ebuf
  import hebuf_pkg::*;
#(
  parameter int IDX_W     = 10,
  parameter int DATA_W    = 16,
  parameter int DEPTH     = 8,
  parameter int MAX_READS = 4,
  parameter int CNT_W     = 16,
  localparam int SLOT_W   = $clog2(DEPTH),
  localparam int USE_W    = $clog2(MAX_READS + 1),
  localparam int OCC_W    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [USE_W-1:0]  wr_uses,
  output logic              wr_stall,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_hit,
  output logic [OCC_W-1:0]  occupancy,
  output logic [OCC_W-1:0]  peak_occ,
  output logic [CNT_W-1:0]  store_cnt,
  output logic [CNT_W-1:0]  hit_cnt,
  output logic [CNT_W-1:0]  miss_cnt
);
  // Named internal events, also seen by the bound checker
  logic [SLOT_W-1:0]    wr_slot, rd_slot;
  logic [MAX_READS-1:0] rd_field, wr_field, new_field;
  logic                 rd_last, slot_freed, wr_collide, wr_accept, rd_miss;

  assign wr_slot   = SLOT_W'(slot_of(32'(wr_idx), DEPTH));
  assign rd_slot   = SLOT_W'(slot_of(32'(rd_idx), DEPTH));
  assign new_field = MAX_READS'(fill_mask(32'(wr_uses), MAX_READS));

  assign rd_hit     = rd_en && (rd_field != '0);
  assign rd_miss    = rd_en && !rd_hit;
  assign rd_last    = rd_hit && last_use(32'(rd_field));
  assign slot_freed = rd_last && (rd_slot == wr_slot);
  assign wr_collide = wr_en && (wr_field != '0) && !slot_freed;
  assign wr_accept  = wr_en && !wr_collide;
  assign wr_stall   = wr_collide;

  hebuf_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk   (clk),
    .we    (wr_accept),
    .wslot (wr_slot),
    .wdata (wr_data),
    .rslot (rd_slot),
    .rdata (rd_data)
  );

  hebuf_flags #(.DEPTH(DEPTH), .FLD_W(MAX_READS)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_slot  (rd_slot),
    .wr_slot  (wr_slot),
    .rd_field (rd_field),
    .wr_field (wr_field),
    .pop_en   (rd_hit),
    .set_en   (wr_accept),
    .set_val  (new_field)
  );

  hebuf_stats #(.OCC_W(OCC_W), .CNT_W(CNT_W)) u_stats (
    .clk    (clk),
    .rst_n  (rst_n),
    .accept (wr_accept),
    .hit    (rd_hit),
    .miss   (rd_miss),
    .free   (rd_last),
    .occ    (occupancy),
    .peak   (peak_occ),
    .st_cnt (store_cnt),
    .h_cnt  (hit_cnt),
    .m_cnt  (miss_cnt)
  );
endmodule

// File: rtl/hebuf_chk.sv
module hebuf_chk #(
  parameter int DEPTH = 8,
  parameter int OCC_W = 4,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             wr_stall,
  input logic             wr_accept,
  input logic             rd_en,
  input logic             rd_hit,
  input logic [OCC_W-1:0] occupancy,
  input logic [OCC_W-1:0] peak_occ,
  input logic [CNT_W-1:0] store_cnt
);
  // R6
  stall_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stall |-> wr_en);
  // R6
  stall_no_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stall |=> store_cnt == $past(store_cnt));
  // R4
  hit_needs_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |-> rd_en);
  // R11
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy <= OCC_W'(DEPTH));
  // R9
  peak_covers_occ_chk: assert property (@(posedge clk) disable iff (!rst_n)
    peak_occ >= occupancy);
  // R9
  peak_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> peak_occ >= $past(peak_occ));
  // R4
  empty_never_hits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (occupancy == '0) |-> !rd_hit);
  // R10
  idle_store_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_accept |=> $stable(store_cnt));
endmodule

bind hash_ebuf hebuf_chk #(.DEPTH(DEPTH), .OCC_W(OCC_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_stall  (wr_stall),
  .wr_accept (wr_accept),
  .rd_en     (rd_en),
  .rd_hit    (rd_hit),
  .occupancy (occupancy),
  .peak_occ  (peak_occ),
  .store_cnt (store_cnt)
);

// File: tb/tb_hash_ebuf.sv
`timescale 1ns/1ps
module tb_hash_ebuf;
  localparam int IDX_W = 10, DATA_W = 16, DEPTH = 8, MAXR = 4, CNT_W = 16;
  localparam int USE_W = $clog2(MAXR + 1);
  localparam int OCC_W = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, rd_en = 0, wr_stall, rd_hit;
  logic [IDX_W-1:0] wr_idx = '0, rd_idx = '0;
  logic [DATA_W-1:0] wr_data = '0, rd_data;
  logic [USE_W-1:0] wr_uses = '0;
  logic [OCC_W-1:0] occupancy, peak_occ;
  logic [CNT_W-1:0] store_cnt, hit_cnt, miss_cnt;

  always #2.5 clk = ~clk;

  hash_ebuf #(.IDX_W(IDX_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .MAX_READS(MAXR),
              .CNT_W(CNT_W)) dut (.*);

  int checks = 0, errors = 0;
  // bench model: remaining uses per slot, data per slot
  int m_left [DEPTH];
  int m_data [DEPTH];
  int m_occ = 0, m_peak = 0, m_st = 0, m_hit = 0, m_miss = 0;

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int uses_eff(int u);
    return (u == 0) ? 1 : ((u > MAXR) ? MAXR : u);
  endfunction

  task automatic check_regs(string tag);
    check(tag, "occupancy", int'(occupancy), m_occ);
    check(tag, "peak_occ", int'(peak_occ), m_peak);
    check(tag, "store_cnt", int'(store_cnt), m_st);
    check(tag, "hit_cnt", int'(hit_cnt), m_hit);
    check(tag, "miss_cnt", int'(miss_cnt), m_miss);
  endtask

  // One cycle; called at a falling edge, returns at the next falling edge
  task automatic cyc(string tag, bit we, int widx, int wd, int wu, bit re, int ridx);
    int hw, hr;
    bit e_hit, e_last, e_stall;
    wr_en = we; wr_idx = IDX_W'(widx); wr_data = DATA_W'(wd); wr_uses = USE_W'(wu);
    rd_en = re; rd_idx = IDX_W'(ridx);
    hw = widx % DEPTH;  // R2: slot is index modulo depth
    hr = ridx % DEPTH;
    e_hit   = re && m_left[hr] > 0;
    e_last  = e_hit && m_left[hr] == 1;
    e_stall = we && m_left[hw] > 0 && !(e_last && hr == hw);
    #1;
    check(tag, "rd_hit", int'(rd_hit), int'(e_hit));
    check(tag, "wr_stall", int'(wr_stall), int'(e_stall));
    if (e_hit) check(tag, "rd_data", int'(rd_data), m_data[hr]);
    // read first, then write
    if (e_hit) begin m_left[hr]--; m_hit++; end
    if (re && !e_hit) m_miss++;
    if (e_last) m_occ--;
    if (we && !e_stall) begin
      m_left[hw] = uses_eff(wu); m_data[hw] = wd & 16'hFFFF;
      m_st++; m_occ++;
      if (m_occ > m_peak) m_peak = m_occ;
    end
    @(posedge clk);
    @(negedge clk);
    wr_en = 0; rd_en = 0;
    check_regs(tag);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin m_left[i] = 0; m_data[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state and every slot misses
    check_regs("R1");
    for (int s = 0; s < DEPTH; s++) cyc("R1", 0, 0, 0, 0, 1, s + 16);

    // R2 R3 R4 R5: every slot, every use count incl. 0 and beyond MAX, aliased indices
    for (int s = 0; s < DEPTH; s++) begin
      for (int u = 0; u <= 5; u++) begin
        int d = 16'h1000 + s * 64 + u;
        cyc("R4", 0, 0, 0, 0, 1, s + DEPTH * 3);              // miss before write
        cyc("R3", 1, s + DEPTH * (u + 1), d, u, 0, 0);       // write
        for (int k = 0; k < uses_eff(u); k++)
          cyc("R5", 0, 0, 0, 0, 1, s + DEPTH * (7 - u));      // alias hits R2
        cyc("R5", 0, 0, 0, 0, 1, s);                          // then misses
      end
    end

    // R6: collision with a slot holding data is stalled and dropped
    cyc("R6", 1, 3, 16'hAAAA, 2, 0, 0);
    cyc("R6", 1, 3 + DEPTH, 16'hBBBB, 3, 0, 0);
    // R6: read with uses left plus write same slot still stalls
    cyc("R6", 1, 3 + 2 * DEPTH, 16'hCCCC, 1, 1, 3);
    // R7: final read plus write same slot: old data out, refill in
    cyc("R7", 1, 3 + 4 * DEPTH, 16'hDDDD, 2, 1, 3);
    cyc("R7", 0, 0, 0, 0, 1, 3);
    cyc("R7", 0, 0, 0, 0, 1, 3 + DEPTH);
    cyc("R7", 0, 0, 0, 0, 1, 3);

    // R11: fill every slot, then one more write stalls
    for (int s = 0; s < DEPTH; s++) cyc("R11", 1, s, 16'h5000 + s, 1, 0, 0);
    cyc("R11", 1, 5 + DEPTH, 16'h6000, 1, 0, 0);
    // R8: read one slot while writing a different, already-full one
    cyc("R8", 1, 2, 16'h7000, 1, 1, 6);
    cyc("R8", 1, 6, 16'h7100, 3, 1, 2);
    for (int s = 0; s < DEPTH; s++) begin
      while (m_left[s] > 0) cyc("R9", 0, 0, 0, 0, 1, s);
    end

    // R8 R9 R10: pseudo-random mix of both ports
    begin
      logic [15:0] lf = 16'hACE1;
      for (int n = 0; n < 1500; n++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        cyc("R10", lf[0], int'(lf[9:4]), int'(lf) ^ n, int'(lf[15:13]) % 6,
            lf[1] | lf[2], int'(lf[14:9]));
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule